// File: doc/BRIEF.md
# I2C Acknowledge Control Unit

This block handles the acknowledge slot of a byte-oriented I2C-style serial channel. It sits beside the shift engine and watches the bus lines. The shift engine supplies its per-byte clock index. The block decides when SDA must be pulled low for an acknowledge. It also records whether the far end acknowledged a byte.

There are two ways to produce an acknowledge. In the software path, writing the force bit pulls SDA low at once and keeps it low until the next SCL falling edge. This path serves transmission and reception with the 8-clock wait. In the automatic path, SDA is pulled low over the ninth SCL clock of every byte while the enable bit stays set.

An output-block bit gates the shift engine's data pull-down, so that a receiver never drives data onto the bus. The acknowledge pull-downs are not gated by it. SDA is open-drain: the block only asserts a pull-down enable. Both SCL and SDA pass through a two-flop synchronizer before any edge is taken from them.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 4'b0100 and `sda_pd_en` is 0. The bit layout is bit0 = force-ack, bit1 = auto-ack enable, bit2 = output block, bit3 = ack seen.
- R2: A write with bit0 = 1 while `chan_en` = 1 raises `sda_pd_en` in the next cycle. It stays high until a falling edge of the synchronized SCL, then drops. The force-ack bit itself still reads 1 after that edge.
- R3: The force-ack bit reads 0 after a `xfer_start` pulse, and while `chan_en` is 0.
- R4: With bit1 = 1, a synchronized SCL falling edge seen while `bit_cnt` = 8 raises `sda_pd_en`. The next SCL falling edge, which ends the ninth clock, lowers it. A falling edge with `bit_cnt` = 7 raises nothing.
- R5: The auto-ack enable bit stays 1 after an automatic acknowledge has gone out. Only a write changes it.
- R6: With bit1 = 0, a falling edge with `bit_cnt` = 8 does not raise `sda_pd_en`.
- R7: The ack-seen bit sets when a synchronized SCL rising edge occurs while `bit_cnt` = 9 and the synchronized SDA is 0. It stays 0 if SDA is 1 at that edge.
- R8: The ack-seen bit reads 0 after a `xfer_start` pulse, and after `chan_en` has been 0.
- R9: With bit2 = 1, `data_low_req` does not reach `sda_pd_en`. With bit2 = 0, it does. A forced acknowledge pulls SDA low whatever bit2 holds.
- R10: A `xfer_start` pulse leaves the output-block bit unchanged.
- R11: Writes to bit3 are ignored. Writing 1 there does not set ack-seen, and writing 0 there does not clear it.
- R12: While `chan_en` is 0, `sda_pd_en` is 0 even when `data_low_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| bit_cnt | input | CNT_W | Index of the current SCL clock within the byte, from the shift engine |
| xfer_start | input | 1 | One-cycle transfer-start strobe |
| chan_en | input | 1 | Channel enable |
| data_low_req | input | 1 | Shift engine requests SDA low for a data bit |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control register write data |
| rd_data | output | 4 | Control and status read-back |
| sda_pd_en | output | 1 | Open-drain SDA pull-down enable |

## Verification
The hardest case to reach is the release of the automatic acknowledge. It needs two SCL falling edges in a row with different clock indices, and each must pass the synchronizer before the next one arrives. The bench steps `bit_cnt` and SCL by hand through indices 7, 8 and 9, and holds each level for several system clocks. It checks the pull-down after each edge. A forced acknowledge is then raised with SCL held high, to show that it lasts until a falling edge and not for a fixed time.

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl #(
  parameter int CNT_W       = 4,
  parameter int ACK_CLK     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             xfer_start,
  input  logic             chan_en,
  input  logic             data_low_req,
  input  logic             wr_en,
  input  logic [3:0]       wr_data,
  output logic [3:0]       rd_data,
  output logic             sda_pd_en
);
  localparam logic [CNT_W-1:0] PRE_ACK = CNT_W'(ACK_CLK - 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(ACK_CLK);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev;
  logic force_ack, force_drive, auto_en, auto_drive, out_block, ack_seen;

  wire scl_s    = scl_sync[SYNC_STAGES-1];
  wire sda_s    = sda_sync[SYNC_STAGES-1];
  wire scl_fall = scl_prev & ~scl_s;
  wire scl_rise = ~scl_prev & scl_s;
  wire clr      = xfer_start | ~chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_prev <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_ack   <= 1'b0;
      force_drive <= 1'b0;
    end else if (clr) begin
      force_ack   <= 1'b0;
      force_drive <= 1'b0;
    end else if (wr_en) begin
      force_ack   <= wr_data[0];
      force_drive <= wr_data[0];
    end else if (scl_fall) begin
      force_drive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en   <= 1'b0;
      out_block <= 1'b1;
    end else if (wr_en) begin
      auto_en   <= wr_data[1];
      out_block <= wr_data[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        auto_drive <= 1'b0;
    else if (clr)      auto_drive <= 1'b0;
    else if (scl_fall) auto_drive <= auto_en && (bit_cnt == PRE_ACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ack_seen <= 1'b0;
    else if (clr) ack_seen <= 1'b0;
    else if (scl_rise && bit_cnt == ACK_IDX && !sda_s) ack_seen <= 1'b1;
  end

  assign rd_data   = {ack_seen, out_block, auto_en, force_ack};
  assign sda_pd_en = chan_en & (force_drive | auto_drive | (data_low_req & ~out_block));
endmodule

// File: rtl/i2c_ack_ctrl_chk.sv
module i2c_ack_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_start,
  input logic       chan_en,
  input logic       wr_en,
  input logic [3:0] wr_data,
  input logic [3:0] rd_data,
  input logic       sda_pd_en
);
  // R2
  force_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && chan_en && !xfer_start) |=> sda_pd_en);
  // R3
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start || !chan_en) |=> !rd_data[0]);
  // R8
  ack_seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start || !chan_en) |=> !rd_data[3]);
  // R10
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !wr_en) |=> $stable(rd_data[2]));
  // R5
  auto_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[1]));
  // R12
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (chan_en || !sda_pd_en));
endmodule

bind i2c_ack_ctrl i2c_ack_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .chan_en(chan_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sda_pd_en(sda_pd_en)
);

// File: tb/i2c_ack_ctrl_tb.sv
module i2c_ack_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic scl_in = 1, sda_in = 1, xfer_start = 0, chan_en = 0, data_low_req = 0, wr_en = 0;
  logic [3:0] bit_cnt = 0, wr_data = 0, rd_data;
  logic sda_pd_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_ack_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .bit_cnt(bit_cnt),
    .xfer_start(xfer_start), .chan_en(chan_en), .data_low_req(data_low_req),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sda_pd_en(sda_pd_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic start_pulse();
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic set_scl(input logic v);
    @(negedge clk); scl_in = v;
    idle(5);
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 4'b0100);
    chk("R1 pd", sda_pd_en, 0);
  endtask

  task automatic t_force();
    chan_en = 1; idle(2);
    wr(4'b0101);
    chk("R2 pd after write", sda_pd_en, 1);
    idle(6);
    chk("R2 pd held scl high", sda_pd_en, 1);
    set_scl(0);
    chk("R2 pd released on fall", sda_pd_en, 0);
    chk("R2 bit still set", rd_data[0], 1);
    set_scl(1);
    start_pulse();
    chk("R3 cleared by start", rd_data[0], 0);
    chk("R10 block kept", rd_data[2], 1);
    wr(4'b0101);
    @(negedge clk); chan_en = 0; idle(2);
    chk("R3 cleared by chan off", rd_data[0], 0);
    chk("R12 pd off", sda_pd_en, 0);
    chan_en = 1; idle(2);
  endtask

  task automatic t_auto();
    wr(4'b0110);
    bit_cnt = 7; set_scl(0);
    chk("R4 no ack at 7", sda_pd_en, 0);
    set_scl(1); bit_cnt = 8; set_scl(0);
    chk("R4 ack at 8 fall", sda_pd_en, 1);
    set_scl(1);
    chk("R4 held through 9th high", sda_pd_en, 1);
    bit_cnt = 9; set_scl(0);
    chk("R4 released at 9th fall", sda_pd_en, 0);
    chk("R5 auto kept", rd_data[1], 1);
    set_scl(1);
  endtask

  task automatic t_no_auto();
    wr(4'b0100);
    set_scl(1); bit_cnt = 8; set_scl(0);
    chk("R6 no ack", sda_pd_en, 0);
    set_scl(1);
  endtask

  task automatic t_detect();
    bit_cnt = 9; set_scl(0);
    sda_in = 0; set_scl(1);
    chk("R7 ack seen", rd_data[3], 1);
    start_pulse();
    chk("R8 cleared by start", rd_data[3], 0);
    set_scl(0); sda_in = 1; set_scl(1);
    chk("R7 nack not seen", rd_data[3], 0);
    wr(4'b1100);
    chk("R11 write 1 ignored", rd_data[3], 0);
    set_scl(0); sda_in = 0; set_scl(1);
    wr(4'b0100);
    chk("R11 write 0 ignored", rd_data[3], 1);
    @(negedge clk); chan_en = 0; idle(2);
    chk("R8 cleared by chan off", rd_data[3], 0);
    chan_en = 1; sda_in = 1; idle(4);
  endtask

  task automatic t_gate();
    data_low_req = 1; idle(1);
    chk("R9 blocked", sda_pd_en, 0);
    wr(4'b0000);
    chk("R9 passed", sda_pd_en, 1);
    @(negedge clk); chan_en = 0; idle(1);
    chk("R12 chan off", sda_pd_en, 0);
    chan_en = 1; data_low_req = 0;
    wr(4'b0101);
    chk("R9 force ack not gated", sda_pd_en, 1);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_force();
    t_auto();
    t_no_auto();
    t_detect();
    t_gate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule